// File: doc/BRIEF.md
# Test Control and Status Register File

This block is the bank of registers that sits in the user clock domain behind a register-bus bridge. Software uses it to drive a storage test. It holds the parameters of a storage operation: a 48-bit start sector, a 48-bit sector count, a 2-bit command code and a 3-bit test-pattern selector. It returns the state of the storage controller and of the pattern checker. Writing the command register raises a one-cycle start request to the storage controller. For data-moving commands it also raises a one-cycle start pulse to the pattern block.

Reads are registered. A read request captures the addressed value one clock later and raises read-valid in that same cycle. The captured value is held until the next request. Byte enables on the bus are accepted and discarded, so every write stores the full word. A 128-word window mirrors the 512 bytes of identify data that the storage controller deposits through its own write port. Addresses that are not in the map read as zero. Writes to addresses that are read-only or not in the map have no effect.

Top module: `tst_reg_bank`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `startAddr`, `sectLen`, `cmdCode`, `pattSel`, `regRdData` are zero and `cmdReq`, `pattStart`, `regRdValid` are low.
- R2: A write to byte offset 0x00 or 0x08 loads all 32 data bits into the low half of `startAddr` or `sectLen`. A write to 0x04 or 0x0C loads data bits [15:0] into bits [47:32] of the same output and drops data bits [31:16]. The new value shows on the port the cycle after the write.
- R3: `regWrByteEn` has no effect: every write stores all of its data bits, whatever the byte enables are.
- R4: A write to 0x10 loads data bits [1:0] into `cmdCode` (00 identify, 01 secure erase, 10 write, 11 read). In the next cycle it raises `cmdReq` for exactly one cycle, together with the new code.
- R5: `pattStart` pulses in the same cycle as `cmdReq`, and only when the new code is 10 or 11.
- R6: A write to 0x14 loads data bits [2:0] into `pattSel` and raises no request.
- R7: `regRdValid` is high exactly in the cycle after each cycle in which `regRdReq` is high, back-to-back requests included. `regRdData` carries the result in that cycle and holds it until the next request.
- R8: Offset 0x100 reads the status word: bit 0 `devBusy`, bit 1 `devErr`, bit 2 `verifyFail`, bits [4:3] `linkSpeed` (00 no link, 01/10/11 first/second/third generation), bits [31:5] zero. The inputs are taken in the request cycle.
- R9: Read-only map: 0x104 `capacity[31:0]`, 0x108 `capacity[47:32]`, 0x10C `errType`, 0x11C `testPins`, 0x120 `failAddr[31:0]`, 0x124 `failAddr[56:32]`, 0x130 `expWord`, 0x140 `rdWord`, 0x150 `curBytes[31:0]`, 0x154 `curBytes[56:32]`. Each value is zero-extended.
- R10: `idWrEn` stores `idWrData` at word `idWrAddr`. A read at 0x2000 + 4*i returns word i, for i from 0 to 127. A read that falls in the same cycle as a store to that word returns the word as it was before the store.
- R11: Reads of addresses outside the map return zero. This includes the write-only offsets 0x00 to 0x14 and the addresses just outside the identify window.
- R12: A write to a read-only or unmapped address changes no writable output and raises neither `cmdReq` nor `pattStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | 16 | Register byte address; bits [1:0] ignored |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regWrByteEn | input | 4 | Byte enables, ignored |
| regRdReq | input | 1 | Read request |
| regRdValid | output | 1 | Read data valid, one cycle after request |
| regRdData | output | 32 | Registered read data |
| cmdReq | output | 1 | One-cycle start request to storage controller |
| cmdCode | output | 2 | Command code |
| startAddr | output | 48 | Start sector |
| sectLen | output | 48 | Sector count |
| pattStart | output | 1 | One-cycle start pulse to pattern block |
| pattSel | output | 3 | Pattern selector |
| devBusy | input | 1 | Controller busy |
| devErr | input | 1 | Controller error |
| verifyFail | input | 1 | Pattern compare failure |
| linkSpeed | input | 2 | Negotiated link speed |
| capacity | input | 48 | Device capacity in sectors |
| errType | input | 32 | Controller error detail |
| testPins | input | 32 | Controller debug word |
| failAddr | input | 57 | Byte address of first compare failure |
| expWord | input | 32 | Expected word at failure |
| rdWord | input | 32 | Received word at failure |
| curBytes | input | 57 | Bytes tested so far |
| idWrEn | input | 1 | Identify data store strobe |
| idWrAddr | input | 7 | Identify word index |
| idWrData | input | 32 | Identify word |

## Verification
The storage controller's identify store port and the register read path can target the same identify word in the same clock. The bench provokes this by raising `idWrEn` for word 5 in the cycle that `regRdReq` addresses 0x2014. The returned data must be the old word, and a second read afterwards must return the new word. A further case runs back-to-back read requests against a queue of expected words. This checks that every request gets exactly one valid cycle with the right data and that nothing is lost or doubled.

// File: rtl/tst_reg_pkg.sv
package tst_reg_pkg;

  // Byte offsets of the register map
  localparam int unsigned OFS_ADDR_LO = 'h000;
  localparam int unsigned OFS_ADDR_HI = 'h004;
  localparam int unsigned OFS_LEN_LO  = 'h008;
  localparam int unsigned OFS_LEN_HI  = 'h00C;
  localparam int unsigned OFS_CMD     = 'h010;
  localparam int unsigned OFS_PATT    = 'h014;
  localparam int unsigned OFS_STAT    = 'h100;
  localparam int unsigned OFS_CAP_LO  = 'h104;
  localparam int unsigned OFS_CAP_HI  = 'h108;
  localparam int unsigned OFS_ERRT    = 'h10C;
  localparam int unsigned OFS_PINS    = 'h11C;
  localparam int unsigned OFS_FAIL_LO = 'h120;
  localparam int unsigned OFS_FAIL_HI = 'h124;
  localparam int unsigned OFS_EXP     = 'h130;
  localparam int unsigned OFS_RDW     = 'h140;
  localparam int unsigned OFS_CUR_LO  = 'h150;
  localparam int unsigned OFS_CUR_HI  = 'h154;
  localparam int unsigned OFS_IDEN    = 'h2000;

  typedef enum logic [3:0] {
    RS_NONE, RS_STAT, RS_CAPLO, RS_CAPHI, RS_ERRT, RS_PINS, RS_FAILLO,
    RS_FAILHI, RS_EXP, RS_RDW, RS_CURLO, RS_CURHI, RS_IDEN
  } rdSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   ldAddrLo;
    logic   ldAddrHi;
    logic   ldLenLo;
    logic   ldLenHi;
    logic   ldCmd;
    logic   ldPatt;
    logic   rdLoad;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/tst_reg_ctrl.sv
module tst_reg_ctrl
  import tst_reg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ID_WORDS = 128,
  localparam int ID_AW   = $clog2(ID_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdReq,
  input  logic              cmdBit1,
  output strobe_t           strb,
  output logic [ID_AW-1:0]  idIdx,
  output logic              cmdReq,
  output logic              pattStart,
  output logic              regRdValid
);

  localparam int ID_LSB = ID_AW + 2;
  localparam logic [ADDR_W-1:0] A_ADDR_LO = ADDR_W'(OFS_ADDR_LO);
  localparam logic [ADDR_W-1:0] A_ADDR_HI = ADDR_W'(OFS_ADDR_HI);
  localparam logic [ADDR_W-1:0] A_LEN_LO  = ADDR_W'(OFS_LEN_LO);
  localparam logic [ADDR_W-1:0] A_LEN_HI  = ADDR_W'(OFS_LEN_HI);
  localparam logic [ADDR_W-1:0] A_CMD     = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_PATT    = ADDR_W'(OFS_PATT);
  localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CAP_LO  = ADDR_W'(OFS_CAP_LO);
  localparam logic [ADDR_W-1:0] A_CAP_HI  = ADDR_W'(OFS_CAP_HI);
  localparam logic [ADDR_W-1:0] A_ERRT    = ADDR_W'(OFS_ERRT);
  localparam logic [ADDR_W-1:0] A_PINS    = ADDR_W'(OFS_PINS);
  localparam logic [ADDR_W-1:0] A_FAIL_LO = ADDR_W'(OFS_FAIL_LO);
  localparam logic [ADDR_W-1:0] A_FAIL_HI = ADDR_W'(OFS_FAIL_HI);
  localparam logic [ADDR_W-1:0] A_EXP     = ADDR_W'(OFS_EXP);
  localparam logic [ADDR_W-1:0] A_RDW     = ADDR_W'(OFS_RDW);
  localparam logic [ADDR_W-1:0] A_CUR_LO  = ADDR_W'(OFS_CUR_LO);
  localparam logic [ADDR_W-1:0] A_CUR_HI  = ADDR_W'(OFS_CUR_HI);
  localparam logic [ADDR_W-1:0] A_IDEN    = ADDR_W'(OFS_IDEN);

  logic [ADDR_W-1:0] wordOfs;
  logic              inIden;

  assign wordOfs = regAddr & ~ADDR_W'(3);
  assign inIden  = (regAddr[ADDR_W-1:ID_LSB] == A_IDEN[ADDR_W-1:ID_LSB]);
  assign idIdx   = regAddr[ID_LSB-1:2];

  always_comb begin
    strb        = '0;
    strb.rdSel  = RS_NONE;
    strb.rdLoad = regRdReq;
    if (regWrEn) begin
      unique case (wordOfs)
        A_ADDR_LO: strb.ldAddrLo = 1'b1;
        A_ADDR_HI: strb.ldAddrHi = 1'b1;
        A_LEN_LO:  strb.ldLenLo  = 1'b1;
        A_LEN_HI:  strb.ldLenHi  = 1'b1;
        A_CMD:     strb.ldCmd    = 1'b1;
        A_PATT:    strb.ldPatt   = 1'b1;
        default:   ;
      endcase
    end
    if (inIden) begin
      strb.rdSel = RS_IDEN;
    end else begin
      unique case (wordOfs)
        A_STAT:    strb.rdSel = RS_STAT;
        A_CAP_LO:  strb.rdSel = RS_CAPLO;
        A_CAP_HI:  strb.rdSel = RS_CAPHI;
        A_ERRT:    strb.rdSel = RS_ERRT;
        A_PINS:    strb.rdSel = RS_PINS;
        A_FAIL_LO: strb.rdSel = RS_FAILLO;
        A_FAIL_HI: strb.rdSel = RS_FAILHI;
        A_EXP:     strb.rdSel = RS_EXP;
        A_RDW:     strb.rdSel = RS_RDW;
        A_CUR_LO:  strb.rdSel = RS_CURLO;
        A_CUR_HI:  strb.rdSel = RS_CURHI;
        default:   strb.rdSel = RS_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdReq     <= 1'b0;
      pattStart  <= 1'b0;
      regRdValid <= 1'b0;
    end else begin
      cmdReq     <= strb.ldCmd;
      pattStart  <= strb.ldCmd & cmdBit1;
      regRdValid <= regRdReq;
    end
  end

endmodule

// File: rtl/tst_reg_data.sv
module tst_reg_data
  import tst_reg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SECT_W   = 48,
  parameter int BYTE_W   = 57,
  parameter int ID_WORDS = 128,
  localparam int ID_AW   = $clog2(ID_WORDS),
  localparam int HI_W    = SECT_W - DATA_W,
  localparam int BHI_W   = BYTE_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ID_AW-1:0]  idIdx,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [1:0]        cmdCode,
  output logic [SECT_W-1:0] startAddr,
  output logic [SECT_W-1:0] sectLen,
  output logic [2:0]        pattSel,
  input  logic              devBusy,
  input  logic              devErr,
  input  logic              verifyFail,
  input  logic [1:0]        linkSpeed,
  input  logic [SECT_W-1:0] capacity,
  input  logic [DATA_W-1:0] errType,
  input  logic [DATA_W-1:0] testPins,
  input  logic [BYTE_W-1:0] failAddr,
  input  logic [DATA_W-1:0] expWord,
  input  logic [DATA_W-1:0] rdWord,
  input  logic [BYTE_W-1:0] curBytes,
  input  logic              idWrEn,
  input  logic [ID_AW-1:0]  idWrAddr,
  input  logic [DATA_W-1:0] idWrData
);

  logic [DATA_W-1:0] idRam [ID_WORDS];
  logic [DATA_W-1:0] rdMux;

  // Parameter registers
  always_ff @(posedge clk) begin
    if (rst) begin
      startAddr <= '0;
      sectLen   <= '0;
      cmdCode   <= '0;
      pattSel   <= '0;
    end else begin
      if (strb.ldAddrLo) startAddr[DATA_W-1:0]      <= regWrData;
      if (strb.ldAddrHi) startAddr[SECT_W-1:DATA_W] <= regWrData[HI_W-1:0];
      if (strb.ldLenLo)  sectLen[DATA_W-1:0]        <= regWrData;
      if (strb.ldLenHi)  sectLen[SECT_W-1:DATA_W]   <= regWrData[HI_W-1:0];
      if (strb.ldCmd)    cmdCode                    <= regWrData[1:0];
      if (strb.ldPatt)   pattSel                    <= regWrData[2:0];
    end
  end

  // Identify data store
  always_ff @(posedge clk) begin
    if (idWrEn) idRam[idWrAddr] <= idWrData;
  end

  // Read source selection
  always_comb begin
    unique case (strb.rdSel)
      RS_STAT:   rdMux = DATA_W'({linkSpeed, verifyFail, devErr, devBusy});
      RS_CAPLO:  rdMux = capacity[DATA_W-1:0];
      RS_CAPHI:  rdMux = DATA_W'(capacity[SECT_W-1:DATA_W]);
      RS_ERRT:   rdMux = errType;
      RS_PINS:   rdMux = testPins;
      RS_FAILLO: rdMux = failAddr[DATA_W-1:0];
      RS_FAILHI: rdMux = DATA_W'(failAddr[BYTE_W-1:DATA_W]);
      RS_EXP:    rdMux = expWord;
      RS_RDW:    rdMux = rdWord;
      RS_CURLO:  rdMux = curBytes[DATA_W-1:0];
      RS_CURHI:  rdMux = DATA_W'(curBytes[BYTE_W-1:DATA_W]);
      RS_IDEN:   rdMux = idRam[idIdx];
      default:   rdMux = '0;
    endcase
  end

  // Pipeline stage of the read path
  always_ff @(posedge clk) begin
    if (rst)              regRdData <= '0;
    else if (strb.rdLoad) regRdData <= rdMux;
  end

  if (BHI_W > DATA_W) begin : g_bad_width
    initial $error("upper byte-count field wider than the data word");
  end

endmodule

// File: rtl/tst_reg_bank.sv
module tst_reg_bank
  import tst_reg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int SECT_W   = 48,
  parameter int BYTE_W   = 57,
  parameter int ID_WORDS = 128
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic                         regWrEn,
  input  logic [DATA_W-1:0]            regWrData,
  input  logic [DATA_W/8-1:0]          regWrByteEn,
  input  logic                         regRdReq,
  output logic                         regRdValid,
  output logic [DATA_W-1:0]            regRdData,
  output logic                         cmdReq,
  output logic [1:0]                   cmdCode,
  output logic [SECT_W-1:0]            startAddr,
  output logic [SECT_W-1:0]            sectLen,
  output logic                         pattStart,
  output logic [2:0]                   pattSel,
  input  logic                         devBusy,
  input  logic                         devErr,
  input  logic                         verifyFail,
  input  logic [1:0]                   linkSpeed,
  input  logic [SECT_W-1:0]            capacity,
  input  logic [DATA_W-1:0]            errType,
  input  logic [DATA_W-1:0]            testPins,
  input  logic [BYTE_W-1:0]            failAddr,
  input  logic [DATA_W-1:0]            expWord,
  input  logic [DATA_W-1:0]            rdWord,
  input  logic [BYTE_W-1:0]            curBytes,
  input  logic                         idWrEn,
  input  logic [$clog2(ID_WORDS)-1:0]  idWrAddr,
  input  logic [DATA_W-1:0]            idWrData
);

  localparam int ID_AW = $clog2(ID_WORDS);

  strobe_t          strb;
  logic [ID_AW-1:0] idIdx;
  logic             unusedByteEn;

  // Byte enables are deliberately discarded: writes are always full-word
  assign unusedByteEn = ^regWrByteEn;

  tst_reg_ctrl #(
    .ADDR_W(ADDR_W), .ID_WORDS(ID_WORDS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdReq(regRdReq), .cmdBit1(regWrData[1]), .strb(strb),
    .idIdx(idIdx), .cmdReq(cmdReq), .pattStart(pattStart),
    .regRdValid(regRdValid)
  );

  tst_reg_data #(
    .DATA_W(DATA_W), .SECT_W(SECT_W), .BYTE_W(BYTE_W), .ID_WORDS(ID_WORDS)
  ) u_data (
    .clk(clk), .rst(rst), .strb(strb), .idIdx(idIdx),
    .regWrData(regWrData), .regRdData(regRdData), .cmdCode(cmdCode),
    .startAddr(startAddr), .sectLen(sectLen), .pattSel(pattSel),
    .devBusy(devBusy), .devErr(devErr), .verifyFail(verifyFail),
    .linkSpeed(linkSpeed), .capacity(capacity), .errType(errType),
    .testPins(testPins), .failAddr(failAddr), .expWord(expWord),
    .rdWord(rdWord), .curBytes(curBytes), .idWrEn(idWrEn),
    .idWrAddr(idWrAddr), .idWrData(idWrData)
  );

endmodule

// File: rtl/tst_reg_chk.sv
module tst_reg_chk
  import tst_reg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SECT_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic              regRdReq,
  input logic              regRdValid,
  input logic [DATA_W-1:0] regRdData,
  input logic              cmdReq,
  input logic [1:0]        cmdCode,
  input logic              pattStart,
  input logic [SECT_W-1:0] startAddr,
  input logic [2:0]        pattSel
);

  logic [ADDR_W-1:0] wordOfs;
  logic              cmdWr;
  assign wordOfs = regAddr & ~ADDR_W'(3);
  assign cmdWr   = regWrEn && (wordOfs == ADDR_W'(OFS_CMD));

  assert_rd_valid_R7: assert property (@(posedge clk) disable iff (rst)
    regRdReq |=> regRdValid);

  assert_rd_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !regRdReq |=> !regRdValid);

  assert_addr_lo_R2: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && wordOfs == ADDR_W'(OFS_ADDR_LO))
      |=> startAddr[DATA_W-1:0] == $past(regWrData));

  assert_cmd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    cmdWr |=> (cmdReq && cmdCode == $past(regWrData[1:0])));

  assert_cmd_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !cmdWr |=> !cmdReq);

  assert_patt_start_R5: assert property (@(posedge clk) disable iff (rst)
    pattStart |-> (cmdReq && cmdCode[1]));

  assert_patt_skip_R5: assert property (@(posedge clk) disable iff (rst)
    (cmdReq && !cmdCode[1]) |-> !pattStart);

  assert_ro_write_R12: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && wordOfs == ADDR_W'(OFS_STAT))
      |=> ($stable(startAddr) && $stable(pattSel) && !cmdReq));

  assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (rst)
    (regRdReq && wordOfs == ADDR_W'('h18)) |=> regRdData == '0);

endmodule

bind tst_reg_bank tst_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
) chk (.*);

// File: tb/tb_tst_reg_bank.sv
module tb_tst_reg_bank;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SECT_W = 48;
  localparam int BYTE_W = 57;
  localparam int ID_WORDS = 128;
  localparam int ID_AW = $clog2(ID_WORDS);

  logic clk = 1'b0;
  logic rst;
  logic [ADDR_W-1:0] regAddr;
  logic regWrEn;
  logic [DATA_W-1:0] regWrData;
  logic [DATA_W/8-1:0] regWrByteEn;
  logic regRdReq;
  logic regRdValid;
  logic [DATA_W-1:0] regRdData;
  logic cmdReq;
  logic [1:0] cmdCode;
  logic [SECT_W-1:0] startAddr;
  logic [SECT_W-1:0] sectLen;
  logic pattStart;
  logic [2:0] pattSel;
  logic devBusy, devErr, verifyFail;
  logic [1:0] linkSpeed;
  logic [SECT_W-1:0] capacity;
  logic [DATA_W-1:0] errType, testPins, expWord, rdWord;
  logic [BYTE_W-1:0] failAddr, curBytes;
  logic idWrEn;
  logic [ID_AW-1:0] idWrAddr;
  logic [DATA_W-1:0] idWrData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] expQ[$];
  string tagQ[$];

  tst_reg_bank dut (.*);

  always #10 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected word for every valid cycle
  always @(negedge clk) begin
    if (!rst && regRdValid) begin
      if (expQ.size() == 0) begin
        check("R7 unexpected valid", 64'(regRdValid), 64'd0);
      end else begin
        automatic logic [DATA_W-1:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(t, 64'(regRdData), 64'(e));
      end
    end
  end

  function automatic logic [DATA_W-1:0] idPat(int i);
    return {8'(i), ~8'(i), 16'h1000 + 16'(i)};
  endfunction

  task automatic regWrite(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                          logic [DATA_W/8-1:0] be);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d; regWrByteEn = be;
    @(negedge clk);
    regWrEn = 1'b0; regWrByteEn = '1;
  endtask

  task automatic regRead(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] e, string tag);
    @(negedge clk);
    regRdReq = 1'b1; regAddr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    regRdReq = 1'b0;
  endtask

  task automatic cmdWrite(logic [1:0] code);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 16'h0010; regWrData = {30'h3FFF_FFFF, code};
    @(negedge clk);
    regWrEn = 1'b0;
    check("R4 cmdReq raised", 64'(cmdReq), 64'd1);
    check("R4 cmdCode", 64'(cmdCode), 64'(code));
    check("R5 pattStart with request", 64'(pattStart), 64'(code[1]));
    @(negedge clk);
    check("R4 cmdReq single cycle", 64'(cmdReq), 64'd0);
    check("R5 pattStart single cycle", 64'(pattStart), 64'd0);
  endtask

  initial begin
    rst = 1'b1; regAddr = '0; regWrEn = 1'b0; regWrData = '0; regWrByteEn = '1;
    regRdReq = 1'b0; devBusy = 1'b0; devErr = 1'b0; verifyFail = 1'b0;
    linkSpeed = 2'b00; capacity = '0; errType = '0; testPins = '0;
    failAddr = '0; expWord = '0; rdWord = '0; curBytes = '0;
    idWrEn = 1'b0; idWrAddr = '0; idWrData = '0;
    repeat (3) @(negedge clk);
    check("R1 startAddr", 64'(startAddr), 64'd0);
    check("R1 sectLen", 64'(sectLen), 64'd0);
    check("R1 cmdCode/pattSel", 64'({cmdCode, pattSel}), 64'd0);
    check("R1 pulses", 64'({cmdReq, pattStart, regRdValid}), 64'd0);
    check("R1 regRdData", 64'(regRdData), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 64'({cmdReq, pattStart, regRdValid}), 64'd0);

    // R2 / R3: parameter registers, byte enables ignored
    regWrite(16'h0000, 32'hDEAD_BEEF, 4'hF);
    regWrite(16'h0004, 32'hABCD_1234, 4'h1);
    check("R2 R3 startAddr", 64'(startAddr), 64'h1234_DEAD_BEEF);
    regWrite(16'h0008, 32'h0000_0100, 4'h0);
    regWrite(16'h000C, 32'hFFFF_0007, 4'h8);
    check("R2 R3 sectLen", 64'(sectLen), 64'h0007_0000_0100);

    // R6: pattern select
    regWrite(16'h0014, 32'hFFFF_FFFC, 4'h0);
    check("R6 pattSel", 64'(pattSel), 64'd4);
    check("R6 no request", 64'({cmdReq, pattStart}), 64'd0);

    // R4 / R5: command codes
    cmdWrite(2'b10);
    cmdWrite(2'b00);
    cmdWrite(2'b01);
    cmdWrite(2'b11);

    // R8: status word, two patterns
    devBusy = 1'b1; devErr = 1'b0; verifyFail = 1'b1; linkSpeed = 2'b11;
    regRead(16'h0100, 32'h0000_001D, "R8 status busy/vfail/gen3");
    devBusy = 1'b0; devErr = 1'b1; verifyFail = 1'b0; linkSpeed = 2'b01;
    regRead(16'h0100, 32'h0000_000A, "R8 status err/gen1");

    // R9: read-only map
    capacity = 48'h00A5_1234_5678;
    errType = 32'hCAFE_F00D; testPins = 32'h0BAD_C0DE;
    failAddr = {25'h1AB_CDEF, 32'h0123_4567};
    curBytes = {25'h000_0123, 32'h89AB_CDEF};
    expWord = 32'h1111_2222; rdWord = 32'h3333_4444;
    regRead(16'h0104, 32'h1234_5678, "R9 capacity low");
    regRead(16'h0108, 32'h0000_00A5, "R9 capacity high");
    regRead(16'h010C, 32'hCAFE_F00D, "R9 error type");
    regRead(16'h011C, 32'h0BAD_C0DE, "R9 test pins");
    regRead(16'h0120, 32'h0123_4567, "R9 fail address low");
    regRead(16'h0124, 32'h01AB_CDEF, "R9 fail address high");
    regRead(16'h0130, 32'h1111_2222, "R9 expected word");
    regRead(16'h0140, 32'h3333_4444, "R9 read word");
    regRead(16'h0150, 32'h89AB_CDEF, "R9 byte count low");
    regRead(16'h0154, 32'h0000_0123, "R9 byte count high");

    // R11: unmapped and write-only offsets read zero
    regRead(16'h0000, 32'h0, "R11 write-only offset");
    regRead(16'h0018, 32'h0, "R11 gap after pattern reg");
    regRead(16'h0200, 32'h0, "R11 unmapped");

    // R12: writes to read-only space
    regWrite(16'h0100, 32'hFFFF_FFFF, 4'hF);
    check("R12 no request on status write", 64'({cmdReq, pattStart}), 64'd0);
    regWrite(16'h0104, 32'h0000_0000, 4'hF);
    regWrite(16'h0300, 32'h0000_0003, 4'hF);
    check("R12 startAddr unchanged", 64'(startAddr), 64'h1234_DEAD_BEEF);
    check("R12 pattSel/cmdCode unchanged", 64'({cmdCode, pattSel}), 64'({2'b11, 3'd4}));
    regRead(16'h0104, 32'h1234_5678, "R12 capacity still live");

    // R10: identify window
    for (int i = 0; i < ID_WORDS; i++) begin
      @(negedge clk);
      idWrEn = 1'b1; idWrAddr = ID_AW'(i); idWrData = idPat(i);
    end
    @(negedge clk);
    idWrEn = 1'b0;
    regRead(16'h2000, idPat(0), "R10 identify word 0");
    regRead(16'h2004, idPat(1), "R10 identify word 1");
    regRead(16'h2100, idPat(64), "R10 identify word 64");
    regRead(16'h21FC, idPat(127), "R10 identify word 127");
    regRead(16'h2200, 32'h0, "R11 past identify window");
    regRead(16'h1FFC, 32'h0, "R11 before identify window");

    // R10: store and read of the same word in one cycle
    @(negedge clk);
    idWrEn = 1'b1; idWrAddr = ID_AW'(5); idWrData = 32'h7777_7777;
    regRdReq = 1'b1; regAddr = 16'h2014;
    expQ.push_back(idPat(5)); tagQ.push_back("R10 same-cycle read returns old word");
    @(negedge clk);
    idWrEn = 1'b0; regRdReq = 1'b0;
    regRead(16'h2014, 32'h7777_7777, "R10 new word after store");

    // R7: back-to-back requests and hold
    @(negedge clk);
    regRdReq = 1'b1; regAddr = 16'h010C;
    expQ.push_back(32'hCAFE_F00D); tagQ.push_back("R7 burst first");
    @(negedge clk);
    regAddr = 16'h2008;
    expQ.push_back(idPat(2)); tagQ.push_back("R7 burst second");
    @(negedge clk);
    regAddr = 16'h0140;
    expQ.push_back(32'h3333_4444); tagQ.push_back("R7 burst third");
    @(negedge clk);
    regRdReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 data held", 64'(regRdData), 64'h3333_4444);
    check("R7 valid low when idle", 64'(regRdValid), 64'd0);
    check("R7 scoreboard drained", 64'(expQ.size()), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule